// File: doc/BRIEF.md
# LCD Display Timing Controller

This block drives a parallel-RGB panel's timing. A host programs the geometry through a small register port: sync pulse widths, porches and the visible area for both axes, plus a pixel clock divider, a clock-edge choice, sync polarities and a four-bit output bus mode. From these the block makes a pixel clock enable, a pixel clock level, horizontal and vertical sync, data-enable and a one-cycle start-of-frame interrupt.

Output comes up in three stages: pixel clock, then sync, then display. Each stage is requested by writing a one to its bit in a write-one "stage on" register. It comes down in the reverse order through a separate "stage off" register. A stage's status bit changes only after a fixed number of system cycles, so software polls it before it moves to the next stage. Requests that would break the order are dropped.

Top module: `lcd_timing_ctrl`

Register map (word address on `addr`). Address 0 is the clock setup: bits [7:0] hold the divider, bit 8 selects the doubled base rate and bit 9 selects the falling edge. Address 1 holds the sync widths. Address 2 holds the vertical porches. Address 3 holds the horizontal porches. Address 4 holds the visible area. Address 5 is the output setup: bit 0 makes horizontal sync active-low, bit 1 makes vertical sync active-low and bits [11:8] hold the bus mode. Address 6 is "stage on" and address 7 is "stage off"; both are write-one, and on each, bit 0 is the clock stage, bit 1 the sync stage and bit 2 the display stage. Address 8 is the read-only stage status, with the same bit order. Address 9 sets the interrupt mask bit (write-one on bit 0), address 10 clears it (write-one on bit 0), and address 11 reads it back.

## Requirements
- R1: After reset the stage status reads 0, the interrupt mask reads 0, and pix_ce, pix_clk_o, hsync_o, vsync_o, de_o and sof_irq_o are all low.
- R2: The timing words are packed as two 16-bit halves. Address 1 holds horizontal sync width minus one in bits [15:0] and vertical sync width minus one in bits [31:16]. Address 2 holds vertical front porch minus one in bits [15:0] and the vertical back porch as a plain line count in bits [31:16]. Address 3 holds horizontal front porch minus one in bits [15:0] and horizontal back porch minus one in bits [31:16]. Address 4 holds visible width minus one in bits [15:0] and visible height minus one in bits [31:16]. A frame therefore lasts (sum of horizontal lengths) times (sum of vertical lengths) pixel steps.
- R3: An enable request for a stage is accepted only if the stage below it is running and settled; the clock stage has no stage below it. A request that fails this test is dropped.
- R4: A disable request for a stage is accepted only if the stage above it is stopped and settled; the display stage has no stage above it. A request that fails this test is dropped.
- R5: An accepted request changes the stage's status bit exactly STAGE_LAT system cycles after the clock edge that sampled the write.
- R6: With the clock stage running, pix_ce pulses at an average rate of step/div per system cycle. step is 2 when bit 8 of address 0 is set and 1 otherwise. A divider value below 2 is treated as 2.
- R7: pix_clk_o equals pix_ce when bit 9 of address 0 is clear and its inverse when bit 9 is set. While the clock stage is stopped, pix_ce and pix_clk_o stay low.
- R8: Each line runs sync, back porch, visible, front porch, and each frame does the same in lines. de_o is high only on visible pixels of visible lines while the display stage runs.
- R9: hsync_o and vsync_o are high during their sync regions. Setting bit 0 (horizontal) or bit 1 (vertical) of address 5 inverts that output. While the sync stage is stopped, each output sits at its inactive level.
- R10: sof_irq_o is a one-cycle pulse when the raster returns to the first pixel of the vertical sync, gated by the interrupt mask. The mask is set by writing one to address 9 and cleared by writing one to address 10.
- R11: out_mode drives bits [11:8] of address 5, and the configuration words read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| pix_ce | output | 1 | Pixel step enable |
| pix_clk_o | output | 1 | Pixel clock level |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| sof_irq_o | output | 1 | Start-of-frame interrupt pulse |
| out_mode | output | 4 | Output bus mode field |

## Verification
The bench measures the frame period and the cycle offset from start-of-frame to the first data-enable. A design that added one to the vertical back porch, or that swapped the porch order, lands on a different cycle count. Out-of-order stage requests are issued in both directions. A design that accepted them would show status bits jumping or the clock stopping under a live raster. The divider is driven with values 0 and 1 and with both base rates. A missing floor would give pixel steps on every cycle instead of at half rate. The mask, polarity and idle levels are read at the pins, so a design that held the sync outputs at 0 when stopped, or let the interrupt through while masked, is caught.

// File: rtl/lcd_tc_pkg.sv
package lcd_tc_pkg;
  localparam int unsigned FW     = 16;
  localparam int unsigned DW     = 2 * FW;
  localparam int unsigned AW     = 4;
  localparam int unsigned DIVW   = 8;
  localparam int unsigned MODEW  = 4;
  localparam int unsigned NSTAGE = 3;
  localparam int unsigned CW     = FW + 3;

  typedef enum logic [AW-1:0] {
    A_CLKCFG   = 4'd0,
    A_SYNCW    = 4'd1,
    A_VPORCH   = 4'd2,
    A_HPORCH   = 4'd3,
    A_ACTIVE   = 4'd4,
    A_OUTCFG   = 4'd5,
    A_STG_ON   = 4'd6,
    A_STG_OFF  = 4'd7,
    A_STG_STAT = 4'd8,
    A_IRQ_ON   = 4'd9,
    A_IRQ_OFF  = 4'd10,
    A_IRQ_MASK = 4'd11
  } reg_addr_e;

  localparam int unsigned STG_CLK  = 0;
  localparam int unsigned STG_SYNC = 1;
  localparam int unsigned STG_DISP = 2;

  typedef struct packed {
    logic [CW-1:0] sync_len;
    logic [CW-1:0] bp_len;
    logic [CW-1:0] act_len;
    logic [CW-1:0] fp_len;
  } axis_t;

  typedef struct packed {
    logic [DIVW-1:0]  div;
    logic             base_x2;
    logic             clk_fall;
    logic             hs_low;
    logic             vs_low;
    logic [MODEW-1:0] mode;
    axis_t            h;
    axis_t            v;
  } cfg_t;

  // stored value is length minus one
  function automatic logic [CW-1:0] len_m1(input logic [FW-1:0] f);
    return CW'(f) + CW'(1);
  endfunction

  // stored value is the length itself
  function automatic logic [CW-1:0] len_raw(input logic [FW-1:0] f);
    return CW'(f);
  endfunction

  function automatic logic [CW-1:0] axis_total(input axis_t a);
    return a.sync_len + a.bp_len + a.act_len + a.fp_len;
  endfunction

  function automatic logic [CW-1:0] axis_act_start(input axis_t a);
    return a.sync_len + a.bp_len;
  endfunction

  function automatic logic [DIVW-1:0] eff_div(input logic [DIVW-1:0] d);
    return (d < DIVW'(2)) ? DIVW'(2) : d;
  endfunction
endpackage

// File: rtl/lcd_tc_regs.sv
module lcd_tc_regs
  import lcd_tc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  input  logic [NSTAGE-1:0] stage_stat,
  output logic [DW-1:0]     rdata,
  output cfg_t              cfg,
  output logic [NSTAGE-1:0] on_req,
  output logic [NSTAGE-1:0] off_req,
  output logic              irq_mask
);
  logic [DIVW-1:0]  r_div;
  logic             r_base_x2, r_clk_fall, r_hs_low, r_vs_low;
  logic [MODEW-1:0] r_mode;
  logic [DW-1:0]    r_syncw, r_vporch, r_hporch, r_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_div      <= '0;
      r_base_x2  <= 1'b0;
      r_clk_fall <= 1'b0;
      r_hs_low   <= 1'b0;
      r_vs_low   <= 1'b0;
      r_mode     <= '0;
      r_syncw    <= '0;
      r_vporch   <= '0;
      r_hporch   <= '0;
      r_active   <= '0;
      irq_mask   <= 1'b0;
    end else if (wr_en) begin
      case (addr)
        A_CLKCFG: begin
          r_div      <= wdata[DIVW-1:0];
          r_base_x2  <= wdata[8];
          r_clk_fall <= wdata[9];
        end
        A_SYNCW:  r_syncw  <= wdata;
        A_VPORCH: r_vporch <= wdata;
        A_HPORCH: r_hporch <= wdata;
        A_ACTIVE: r_active <= wdata;
        A_OUTCFG: begin
          r_hs_low <= wdata[0];
          r_vs_low <= wdata[1];
          r_mode   <= wdata[8 +: MODEW];
        end
        A_IRQ_ON:  if (wdata[0]) irq_mask <= 1'b1;
        A_IRQ_OFF: if (wdata[0]) irq_mask <= 1'b0;
        default: ;
      endcase
    end
  end

  assign on_req  = (wr_en && addr == A_STG_ON)  ? wdata[NSTAGE-1:0] : '0;
  assign off_req = (wr_en && addr == A_STG_OFF) ? wdata[NSTAGE-1:0] : '0;

  always_comb begin
    cfg          = '0;
    cfg.div      = r_div;
    cfg.base_x2  = r_base_x2;
    cfg.clk_fall = r_clk_fall;
    cfg.hs_low   = r_hs_low;
    cfg.vs_low   = r_vs_low;
    cfg.mode     = r_mode;
    cfg.h.sync_len = len_m1(r_syncw[FW-1:0]);
    cfg.v.sync_len = len_m1(r_syncw[DW-1:FW]);
    cfg.v.fp_len   = len_m1(r_vporch[FW-1:0]);
    cfg.v.bp_len   = len_raw(r_vporch[DW-1:FW]);
    cfg.h.fp_len   = len_m1(r_hporch[FW-1:0]);
    cfg.h.bp_len   = len_m1(r_hporch[DW-1:FW]);
    cfg.h.act_len  = len_m1(r_active[FW-1:0]);
    cfg.v.act_len  = len_m1(r_active[DW-1:FW]);
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CLKCFG:   rdata = DW'({r_clk_fall, r_base_x2, r_div});
      A_SYNCW:    rdata = r_syncw;
      A_VPORCH:   rdata = r_vporch;
      A_HPORCH:   rdata = r_hporch;
      A_ACTIVE:   rdata = r_active;
      A_OUTCFG:   rdata = DW'({r_mode, 6'd0, r_vs_low, r_hs_low});
      A_STG_STAT: rdata = DW'(stage_stat);
      A_IRQ_MASK: rdata = DW'(irq_mask);
      default:    rdata = '0;
    endcase
  end

  // R10: a mask-off write always leaves the mask clear
  a_r10_mask_off: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_IRQ_OFF && wdata[0]) |=> !irq_mask);
endmodule

// File: rtl/lcd_tc_stage_seq.sv
module lcd_tc_stage_seq
  import lcd_tc_pkg::*;
#(
  parameter int unsigned LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSTAGE-1:0] on_req,
  input  logic [NSTAGE-1:0] off_req,
  output logic [NSTAGE-1:0] running
);
  localparam int unsigned LW = $clog2(LAT + 1);

  logic [NSTAGE-1:0] busy, target, acc_on, acc_off, lower_ok, upper_clear;

  for (genvar k = 0; k < NSTAGE; k++) begin : g_stg
    logic [LW-1:0] cnt;

    if (k == 0) begin : g_bottom
      assign lower_ok[k] = 1'b1;
    end else begin : g_mid_lo
      assign lower_ok[k] = running[k-1] & ~busy[k-1];
    end

    if (k == NSTAGE - 1) begin : g_top
      assign upper_clear[k] = 1'b1;
    end else begin : g_mid_hi
      assign upper_clear[k] = ~running[k+1] & ~busy[k+1];
    end

    assign acc_on[k]  = on_req[k] & lower_ok[k] & ~busy[k];
    assign acc_off[k] = off_req[k] & upper_clear[k] & ~busy[k] & ~acc_on[k];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        busy[k]    <= 1'b0;
        target[k]  <= 1'b0;
        running[k] <= 1'b0;
        cnt        <= '0;
      end else if (acc_on[k] || acc_off[k]) begin
        busy[k]   <= 1'b1;
        target[k] <= acc_on[k];
        cnt       <= LW'(LAT);
      end else if (busy[k]) begin
        if (cnt <= LW'(1)) begin
          busy[k]    <= 1'b0;
          running[k] <= target[k];
        end else begin
          cnt <= cnt - LW'(1);
        end
      end
    end

    // R5: a status bit moves only at the end of a pending request
    a_r5_no_spont: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(busy[k]) |-> $stable(running[k]));

    if (k > 0) begin : g_chain
      // R3/R4: an upper stage never runs above a stopped one
      a_r3_chain: assert property (@(posedge clk) disable iff (!rst_n)
        running[k] |-> running[k-1]);
    end
  end
endmodule

// File: rtl/lcd_tc_pixclk.sv
module lcd_tc_pixclk
  import lcd_tc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [DIVW-1:0] div,
  input  logic            base_x2,
  input  logic            clk_fall,
  output logic            pix_ce,
  output logic            pix_clk_o
);
  localparam int unsigned AccW = DIVW + 1;

  logic [AccW-1:0] acc, sum, rem, d;
  logic            hit, ce_q;

  assign d   = AccW'(eff_div(div));
  assign sum = acc + (base_x2 ? AccW'(2) : AccW'(1));
  assign hit = sum >= d;
  assign rem = sum - d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      ce_q <= 1'b0;
    end else if (!run) begin
      acc  <= '0;
      ce_q <= 1'b0;
    end else begin
      ce_q <= hit;
      if (hit) acc <= (rem >= d) ? '0 : rem;
      else     acc <= sum;
    end
  end

  assign pix_ce    = ce_q & run;
  assign pix_clk_o = run & (ce_q ^ clk_fall);

  // R6: with unit step the floor of 2 forbids back-to-back pixel steps
  a_r6_div_floor: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pix_ce) && $past(run) && run && !base_x2 && !$past(base_x2)
     && $past(div) == div && $past(acc) < $past(d)) |-> !pix_ce);
endmodule

// File: rtl/lcd_tc_raster.sv
module lcd_tc_raster
  import lcd_tc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sync_run,
  input  logic  disp_run,
  input  logic  pix_ce,
  input  axis_t h,
  input  axis_t v,
  input  logic  hs_low,
  input  logic  vs_low,
  input  logic  irq_mask,
  output logic  hsync_o,
  output logic  vsync_o,
  output logic  de_o,
  output logic  sof_o
);
  logic [CW-1:0] hcnt, vcnt, htot, vtot, h_as, v_as;
  logic step, h_last, v_last, sof_q;
  logic h_in_sync, v_in_sync, h_in_act, v_in_act;

  assign htot   = axis_total(h);
  assign vtot   = axis_total(v);
  assign h_as   = axis_act_start(h);
  assign v_as   = axis_act_start(v);
  assign step   = sync_run & pix_ce;
  assign h_last = hcnt >= htot - CW'(1);
  assign v_last = vcnt >= vtot - CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt  <= '0;
      vcnt  <= '0;
      sof_q <= 1'b0;
    end else if (!sync_run) begin
      hcnt  <= '0;
      vcnt  <= '0;
      sof_q <= 1'b0;
    end else begin
      sof_q <= step & h_last & v_last;
      if (step) begin
        if (h_last) begin
          hcnt <= '0;
          vcnt <= v_last ? '0 : vcnt + CW'(1);
        end else begin
          hcnt <= hcnt + CW'(1);
        end
      end
    end
  end

  assign h_in_sync = sync_run & (hcnt < h.sync_len);
  assign v_in_sync = sync_run & (vcnt < v.sync_len);
  assign h_in_act  = (hcnt >= h_as) && (hcnt < h_as + h.act_len);
  assign v_in_act  = (vcnt >= v_as) && (vcnt < v_as + v.act_len);

  assign hsync_o = h_in_sync ^ hs_low;
  assign vsync_o = v_in_sync ^ vs_low;
  assign de_o    = disp_run & h_in_act & v_in_act;
  assign sof_o   = sof_q & irq_mask;

  // R8: data enable never overlaps the horizontal sync pulse
  a_r8_de_not_in_sync: assert property (@(posedge clk) disable iff (!rst_n)
    de_o |-> !h_in_sync);
  // R10: start of frame lands on the first pixel of both sync regions
  a_r10_sof_at_sync: assert property (@(posedge clk) disable iff (!rst_n)
    sof_q |-> (h_in_sync && v_in_sync));
  // R10: the pulse lasts one cycle
  a_r10_sof_single: assert property (@(posedge clk) disable iff (!rst_n)
    sof_q |=> !sof_q);
endmodule

// File: rtl/lcd_timing_ctrl.sv
module lcd_timing_ctrl
  import lcd_tc_pkg::*;
#(
  parameter int unsigned STAGE_LAT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic             pix_ce,
  output logic             pix_clk_o,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             de_o,
  output logic             sof_irq_o,
  output logic [MODEW-1:0] out_mode
);
  cfg_t              cfg;
  logic [NSTAGE-1:0] on_req, off_req, running;
  logic              irq_mask;

  lcd_tc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .stage_stat(running), .rdata(rdata), .cfg(cfg),
    .on_req(on_req), .off_req(off_req), .irq_mask(irq_mask)
  );

  lcd_tc_stage_seq #(.LAT(STAGE_LAT)) u_seq (
    .clk(clk), .rst_n(rst_n), .on_req(on_req), .off_req(off_req),
    .running(running)
  );

  lcd_tc_pixclk u_pix (
    .clk(clk), .rst_n(rst_n), .run(running[STG_CLK]), .div(cfg.div),
    .base_x2(cfg.base_x2), .clk_fall(cfg.clk_fall),
    .pix_ce(pix_ce), .pix_clk_o(pix_clk_o)
  );

  lcd_tc_raster u_ras (
    .clk(clk), .rst_n(rst_n), .sync_run(running[STG_SYNC]),
    .disp_run(running[STG_DISP]), .pix_ce(pix_ce), .h(cfg.h), .v(cfg.v),
    .hs_low(cfg.hs_low), .vs_low(cfg.vs_low), .irq_mask(irq_mask),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .sof_o(sof_irq_o)
  );

  assign out_mode = cfg.mode;

  // R7: no pixel activity while the clock stage is stopped
  a_r7_clk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !running[STG_CLK] |-> (!pix_ce && !pix_clk_o));
  // R8: data enable only while the display stage runs
  a_r8_de_gate: assert property (@(posedge clk) disable iff (!rst_n)
    de_o |-> running[STG_DISP]);
endmodule

// File: tb/lcd_timing_ctrl_tb_top.sv
`timescale 1ns/1ps
module lcd_timing_ctrl_tb_top;
  localparam int LAT = 4;
  localparam int H_SYNC = 2, H_BP = 3, H_ACT = 4, H_FP = 2;
  localparam int V_SYNC = 1, V_BP = 2, V_ACT = 3, V_FP = 1;
  localparam int DIVV = 2;
  localparam int HT = H_SYNC + H_BP + H_ACT + H_FP;
  localparam int VT = V_SYNC + V_BP + V_ACT + V_FP;
  localparam int FRAME = HT * VT * DIVV;
  localparam logic [31:0] W_SYNC = {16'(V_SYNC - 1), 16'(H_SYNC - 1)};
  localparam logic [31:0] W_VP   = {16'(V_BP), 16'(V_FP - 1)};
  localparam logic [31:0] W_HP   = {16'(H_BP - 1), 16'(H_FP - 1)};
  localparam logic [31:0] W_ACT  = {16'(V_ACT - 1), 16'(H_ACT - 1)};

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [3:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic pix_ce, pix_clk_o, hsync_o, vsync_o, de_o, sof_irq_o;
  logic [3:0] out_mode;

  int checks = 0, errors = 0;
  typedef struct { string req; int unsigned val; } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  lcd_timing_ctrl #(.STAGE_LAT(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pix_ce(pix_ce), .pix_clk_o(pix_clk_o), .hsync_o(hsync_o),
    .vsync_o(vsync_o), .de_o(de_o), .sof_irq_o(sof_irq_o), .out_mode(out_mode)
  );

  task automatic sb_expect(input string req, input int unsigned v);
    exp_t e; e.req = req; e.val = v; exp_q.push_back(e);
  endtask

  task automatic sb_observe(input int unsigned act);
    exp_t e;
    checks++;
    if (exp_q.size() == 0) begin
      errors++; $display("FAIL scoreboard empty actual=%0d", act);
    end else begin
      e = exp_q.pop_front();
      if (act != e.val) begin
        errors++;
        $display("FAIL %s actual=%0d expected=%0d", e.req, act, e.val);
      end
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output int unsigned v);
    addr = a; #1; v = rdata;
  endtask

  task automatic settle(); repeat (LAT + 3) @(negedge clk); endtask

  task automatic poll_stat(input int bitn, input logic want, output int unsigned n);
    int unsigned v;
    n = 0;
    rd(4'd8, v);
    while (v[bitn] != want && n < 100) begin
      @(negedge clk); n++; rd(4'd8, v);
    end
  endtask

  task automatic count_sig(input int cycles, input int which, output int unsigned n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      case (which)
        0: n += pix_ce;
        1: n += de_o;
        2: n += hsync_o;
        3: n += vsync_o;
        4: n += sof_irq_o;
        5: n += (pix_clk_o != (pix_ce ^ 1'b1));
        default: n += pix_clk_o;
      endcase
      @(negedge clk);
    end
  endtask

  task automatic wait_sof();
    int guard = 0;
    while (!sof_irq_o && guard < 2000) begin @(negedge clk); guard++; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned v, n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(4'd8, v); sb_expect("R1 status", 0); sb_observe(v);
    rd(4'd11, v); sb_expect("R1 mask", 0); sb_observe(v);
    sb_expect("R1 outputs", 0);
    sb_observe({pix_ce, pix_clk_o, hsync_o, vsync_o, de_o, sof_irq_o});

    wr(4'd1, W_SYNC); wr(4'd2, W_VP); wr(4'd3, W_HP); wr(4'd4, W_ACT);
    wr(4'd0, 32'(DIVV));
    // R11 readback
    rd(4'd2, v); sb_expect("R11 vporch readback", W_VP); sb_observe(v);

    // R3 sync/display request while clock stage is off is dropped
    wr(4'd6, 32'b110); settle();
    rd(4'd8, v); sb_expect("R3 out-of-order enable dropped", 0); sb_observe(v);

    // R5 clock stage latency
    wr(4'd6, 32'b001); poll_stat(0, 1'b1, n);
    sb_expect("R5 enable latency", LAT); sb_observe(n);

    // R6 divider and base rate
    repeat (10) @(negedge clk);
    count_sig(60, 0, n); sb_expect("R6 div2 step1", 30); sb_observe(n);
    wr(4'd0, 32'd6); repeat (10) @(negedge clk);
    count_sig(60, 0, n); sb_expect("R6 div6 step1", 10); sb_observe(n);
    wr(4'd0, 32'h104); repeat (10) @(negedge clk);
    count_sig(60, 0, n); sb_expect("R6 div4 step2", 30); sb_observe(n);
    wr(4'd0, 32'd1); repeat (10) @(negedge clk);
    count_sig(60, 0, n); sb_expect("R6 div1 floored", 30); sb_observe(n);
    wr(4'd0, 32'h100); repeat (10) @(negedge clk);
    count_sig(60, 0, n); sb_expect("R6 div0 floored step2", 60); sb_observe(n);

    // R7 falling-edge clock level
    wr(4'd0, 32'h200 | DIVV); repeat (10) @(negedge clk);
    count_sig(40, 5, n); sb_expect("R7 inverted clock", 0); sb_observe(n);
    wr(4'd0, 32'(DIVV)); repeat (10) @(negedge clk);

    // bring up sync, display, interrupt
    wr(4'd6, 32'b010); settle();
    wr(4'd6, 32'b100); settle();
    wr(4'd9, 32'd1);
    rd(4'd8, v); sb_expect("R3 all stages up", 7); sb_observe(v);

    // R2 frame period
    wait_sof(); n = 0;
    @(negedge clk); n++;
    while (!sof_irq_o && n < 2000) begin @(negedge clk); n++; end
    sb_expect("R2 frame period", FRAME); sb_observe(n);
    // R8 raster ordering: first data enable after frame start
    n = 0;
    while (!de_o && n < 2000) begin @(negedge clk); n++; end
    sb_expect("R8 first de offset",
              ((V_SYNC + V_BP) * HT + H_SYNC + H_BP) * DIVV); sb_observe(n);
    wait_sof();
    count_sig(FRAME, 1, n); sb_expect("R8 de cycles", H_ACT * V_ACT * DIVV); sb_observe(n);
    count_sig(FRAME, 2, n); sb_expect("R9 hsync cycles", H_SYNC * VT * DIVV); sb_observe(n);
    count_sig(FRAME, 3, n); sb_expect("R9 vsync cycles", V_SYNC * HT * DIVV); sb_observe(n);
    count_sig(2 * FRAME, 4, n); sb_expect("R10 sof count", 2); sb_observe(n);

    // R9 polarity, R11 mode port
    wr(4'd5, 32'h0A03);
    sb_expect("R11 out_mode", 4'hA); sb_observe(out_mode);
    count_sig(FRAME, 2, n); sb_expect("R9 hsync low", FRAME - H_SYNC * VT * DIVV); sb_observe(n);
    count_sig(FRAME, 3, n); sb_expect("R9 vsync low", FRAME - V_SYNC * HT * DIVV); sb_observe(n);

    // R10 mask
    wr(4'd10, 32'd1);
    rd(4'd11, v); sb_expect("R10 mask cleared", 0); sb_observe(v);
    count_sig(3 * FRAME, 4, n); sb_expect("R10 masked sof", 0); sb_observe(n);

    // R4 out-of-order disables dropped
    wr(4'd7, 32'b001); settle();
    rd(4'd8, v); sb_expect("R4 clock off dropped", 7); sb_observe(v);
    wr(4'd7, 32'b010); settle();
    rd(4'd8, v); sb_expect("R4 sync off dropped", 7); sb_observe(v);
    // reverse order teardown
    wr(4'd7, 32'b100); poll_stat(2, 1'b0, n);
    sb_expect("R5 disable latency", LAT); sb_observe(n);
    count_sig(FRAME, 1, n); sb_expect("R8 de off", 0); sb_observe(n);
    wr(4'd7, 32'b010); settle();
    rd(4'd8, v); sb_expect("R4 sync stopped", 1); sb_observe(v);
    count_sig(50, 2, n); sb_expect("R9 idle hsync level", 50); sb_observe(n);
    wr(4'd7, 32'b001); settle();
    rd(4'd8, v); sb_expect("R4 clock stopped", 0); sb_observe(v);
    count_sig(50, 0, n); sb_expect("R7 no ce when stopped", 0); sb_observe(n);
    count_sig(50, 6, n); sb_expect("R7 no clock when stopped", 0); sb_observe(n);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule